// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous memory with two identical ports, left and right. Each port can read or write any word of a shared array on every clock edge, and both ports may do so in the same cycle. A port reads only when its enable and output enable are high and write select is low. The read word appears on that port's data output one clock after the request and stays there until the next read on that port.

The two highest addresses also work as mailboxes between the ports. When the left port writes the all-ones address, the interrupt output of the right port goes low. It stays low until the right port reads that address. The address just below all-ones works the same way in the other direction: a right-port write sends an interrupt to the left port, and a left-port read clears it. Both mailbox words keep their data like any other location. Each port has an active-low busy input. While it is low, it blocks any flag change caused by that port's own access.

Top module: `dpram_mailbox`

## Requirements
- R1: While `rst_ni` is low, both interrupt outputs are high and both read-data outputs are zero. This holds at power-up and also when reset is asserted during operation.
- R2: A read (enable=1, write select=0, output enable=1) at address A returns the stored word on that port's data output after the next rising edge. The output keeps that value until the next read on that port.
- R3: A write (enable=1, write select=1) stores the data at the address. The two ports can write different addresses in the same cycle.
- R4: If both ports write the same address in the same cycle, the left port's data is stored.
- R5: A left-port write to the all-ones address drives `r_int_no` low from the next rising edge on.
- R6: A right-port read of the all-ones address drives `r_int_no` high from the next rising edge on.
- R7: A right-port write to address all-ones minus one drives `l_int_no` low. A left-port read of that address drives `l_int_no` high.
- R8: If a port's busy input is low, no flag changes due to that port's access. The data transfer still takes place.
- R9: If a flag is set and cleared in the same cycle, it ends up set.
- R10: Mailbox locations store data like other words. A port reading the mailbox that interrupts the other port does not change either flag.
- R11: An access with enable high, write select low and output enable low is not a read. It does not clear a flag and does not update the data output.
- R12: If one port reads an address while the other port writes it in the same cycle, the read returns the word that was stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_i | input | 1 | Left enable |
| l_we_i | input | 1 | Left write select (1 = write) |
| l_oe_i | input | 1 | Left output enable |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_rdata_o | output | DATA_W | Left read data |
| l_busy_ni | input | 1 | Left busy, active low, blocks flag changes from left accesses |
| l_int_no | output | 1 | Left interrupt, active low |
| r_ce_i | input | 1 | Right enable |
| r_we_i | input | 1 | Right write select (1 = write) |
| r_oe_i | input | 1 | Right output enable |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_rdata_o | output | DATA_W | Right read data |
| r_busy_ni | input | 1 | Right busy, active low, blocks flag changes from right accesses |
| r_int_no | output | 1 | Right interrupt, active low |

## Verification
The hardest case to reach is one edge where a flag is set and cleared together. It needs a pending flag, then in one cycle a left write of the top address and a right read of the same word. The stimulus first posts one word to the mailbox. It then writes a second word while the receiver reads, and checks that the read returns the first word and that the interrupt stays low. A final read clears it. Busy blocking is checked separately for the setting port and for the clearing port. In each case the data transfer is also confirmed.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef struct packed {
    logic wr;     // qualified write
    logic rd;     // qualified read
    logic mb_hi;  // address is all-ones
    logic mb_lo;  // address is all-ones minus one
  } port_dec_t;
endpackage

// File: rtl/dpm_port.sv
module dpm_port
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              ce_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  output port_dec_t         dec_o
);
  localparam logic [ADDR_W-1:0] MB_HI = '1;
  localparam logic [ADDR_W-1:0] MB_LO = MB_HI - ADDR_W'(1);

  always_comb begin
    dec_o.wr    = ce_i & we_i;
    dec_o.rd    = ce_i & ~we_i & oe_i;
    dec_o.mb_hi = (addr_i == MB_HI);
    dec_o.mb_lo = (addr_i == MB_LO);
  end
endmodule

// File: rtl/dpm_array.sv
module dpm_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        we_i,     // [0] left, [1] right
  input  logic [1:0]        re_i,
  input  logic [ADDR_W-1:0] addr_i [2],
  input  logic [DATA_W-1:0] wdata_i [2],
  output logic [DATA_W-1:0] rdata_o [2]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // right first, left last: left wins on same-address collision
  always_ff @(posedge clk_i) begin
    if (we_i[1]) mem[addr_i[1]] <= wdata_i[1];
    if (we_i[0]) mem[addr_i[0]] <= wdata_i[0];
  end

  for (genvar g = 0; g < 2; g++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_o[g] <= '0;
      else if (re_i[g]) rdata_o[g] <= mem[addr_i[g]];
    end
  end
endmodule

// File: rtl/dpm_flag.sv
module dpm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic set_ok_i,
  input  logic clr_i,
  input  logic clr_ok_i,
  output logic int_no
);
  logic pend_q;
  logic set_en, clr_en;

  assign set_en = set_i & set_ok_i;
  assign clr_en = clr_i & clr_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_en) pend_q <= 1'b1;   // set has priority
    else if (clr_en) pend_q <= 1'b0;
  end

  assign int_no = ~pend_q;

  // R5
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && set_ok_i) |=> !int_no);
  // R6
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && clr_ok_i && !set_i) |=> int_no);
  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(set_i && set_ok_i) && !(clr_i && clr_ok_i)) |=> $stable(int_no));
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              l_busy_ni,
  output logic              l_int_no,
  input  logic              r_ce_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  input  logic              r_busy_ni,
  output logic              r_int_no
);
  port_dec_t l_dec, r_dec;

  dpm_port #(.ADDR_W(ADDR_W)) u_l_port (
    .ce_i(l_ce_i), .we_i(l_we_i), .oe_i(l_oe_i), .addr_i(l_addr_i), .dec_o(l_dec)
  );
  dpm_port #(.ADDR_W(ADDR_W)) u_r_port (
    .ce_i(r_ce_i), .we_i(r_we_i), .oe_i(r_oe_i), .addr_i(r_addr_i), .dec_o(r_dec)
  );

  logic [ADDR_W-1:0] arr_addr  [2];
  logic [DATA_W-1:0] arr_wdata [2];
  logic [DATA_W-1:0] arr_rdata [2];

  assign arr_addr[0]  = l_addr_i;
  assign arr_addr[1]  = r_addr_i;
  assign arr_wdata[0] = l_wdata_i;
  assign arr_wdata[1] = r_wdata_i;

  dpm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    ({r_dec.wr, l_dec.wr}),
    .re_i    ({r_dec.rd, l_dec.rd}),
    .addr_i  (arr_addr),
    .wdata_i (arr_wdata),
    .rdata_o (arr_rdata)
  );

  assign l_rdata_o = arr_rdata[0];
  assign r_rdata_o = arr_rdata[1];

  // flag toward right: left posts to all-ones, right drains it
  dpm_flag u_r_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (l_dec.wr & l_dec.mb_hi),
    .set_ok_i (l_busy_ni),
    .clr_i    (r_dec.rd & r_dec.mb_hi),
    .clr_ok_i (r_busy_ni),
    .int_no   (r_int_no)
  );

  // flag toward left: right posts to all-ones minus one, left drains it
  dpm_flag u_l_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (r_dec.wr & r_dec.mb_lo),
    .set_ok_i (r_busy_ni),
    .clr_i    (l_dec.rd & l_dec.mb_lo),
    .clr_ok_i (l_busy_ni),
    .int_no   (l_int_no)
  );

  // R9
  set_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ce_i && l_we_i && (&l_addr_i) && l_busy_ni &&
     r_ce_i && !r_we_i && r_oe_i && (&r_addr_i) && r_busy_ni) |=> !r_int_no);
  // R11
  no_oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_ce_i && !l_we_i && !l_oe_i) |=> $stable(l_rdata_o));
endmodule

// File: tb/sim_dpram_mailbox.sv
module sim_dpram_mailbox;
  localparam int AW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic l_ce = 0, l_we = 0, l_oe = 0, l_busy_n = 1;
  logic r_ce = 0, r_we = 0, r_oe = 0, r_busy_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wd = '0, r_wd = '0;
  logic [DW-1:0] l_rd, r_rd;
  logic l_int_n, r_int_n;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_ce_i(l_ce), .l_we_i(l_we), .l_oe_i(l_oe), .l_addr_i(l_addr),
    .l_wdata_i(l_wd), .l_rdata_o(l_rd), .l_busy_ni(l_busy_n), .l_int_no(l_int_n),
    .r_ce_i(r_ce), .r_we_i(r_we), .r_oe_i(r_oe), .r_addr_i(r_addr),
    .r_wdata_i(r_wd), .r_rdata_o(r_rd), .r_busy_ni(r_busy_n), .r_int_no(r_int_n)
  );

  typedef struct packed {
    logic          lw, lr;
    logic [AW-1:0] la;
    logic [DW-1:0] ld;
    logic          rw, rr;
    logic [AW-1:0] ra;
    logic [DW-1:0] rd;
    logic          ckl;
    logic [DW-1:0] el;
    logic          ckr;
    logic [DW-1:0] er;
    logic          eli, eri;
    logic [31:0]   tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1,0,10'd5,16'hA5A5,   1,0,10'd9,16'h0909,    0,16'h0,   0,16'h0,   1,1,"R3"},
    '{0,1,10'd9,16'h0,      0,1,10'd5,16'h0,       1,16'h0909,1,16'hA5A5,1,1,"R2"},
    '{1,0,10'd7,16'h1111,   1,0,10'd7,16'h2222,    0,16'h0,   0,16'h0,   1,1,"R4"},
    '{0,1,10'd7,16'h0,      0,1,10'd7,16'h0,       1,16'h1111,1,16'h1111,1,1,"R4"},
    '{1,0,10'd1023,16'hBEEF,0,0,10'd0,16'h0,       0,16'h0,   0,16'h0,   1,0,"R5"},
    '{0,0,10'd0,16'h0,      0,1,10'd1023,16'h0,    0,16'h0,   1,16'hBEEF,1,1,"R6"},
    '{0,0,10'd0,16'h0,      1,0,10'd1022,16'hCAFE, 0,16'h0,   0,16'h0,   0,1,"R7"},
    '{0,1,10'd1022,16'h0,   0,0,10'd0,16'h0,       1,16'hCAFE,0,16'h0,   1,1,"R7"},
    '{1,0,10'd5,16'h5555,   0,1,10'd5,16'h0,       0,16'h0,   1,16'hA5A5,1,1,"R12"},
    '{0,0,10'd0,16'h0,      0,1,10'd5,16'h0,       0,16'h0,   1,16'h5555,1,1,"R12"},
    '{1,0,10'd1023,16'h0001,0,0,10'd0,16'h0,       0,16'h0,   0,16'h0,   1,0,"R5"},
    '{1,0,10'd1023,16'h0002,0,1,10'd1023,16'h0,    0,16'h0,   1,16'h0001,1,0,"R9"},
    '{0,0,10'd0,16'h0,      0,1,10'd1023,16'h0,    0,16'h0,   1,16'h0002,1,1,"R10"},
    '{0,1,10'd1023,16'h0,   0,1,10'd1022,16'h0,    1,16'h0002,1,16'hCAFE,1,1,"R10"}
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    l_ce = 0; l_we = 0; l_oe = 0;
    r_ce = 0; r_we = 0; r_oe = 0;
  endtask

  task automatic l_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce = 1; l_we = w; l_oe = ~w; l_addr = a; l_wd = d;
  endtask

  task automatic r_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce = 1; r_we = w; r_oe = ~w; r_addr = a; r_wd = d;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    // R1 power-up reset
    chk("R1", {15'd0, l_int_n}, 16'd1);
    chk("R1", {15'd0, r_int_n}, 16'd1);
    chk("R1", l_rd, 16'h0);
    chk("R1", r_rd, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      idle();
      if (VECS[i].lw || VECS[i].lr) l_op(VECS[i].lw, VECS[i].la, VECS[i].ld);
      if (VECS[i].rw || VECS[i].rr) r_op(VECS[i].rw, VECS[i].ra, VECS[i].rd);
      tick();
      if (VECS[i].ckl) chk(string'(VECS[i].tag), l_rd, VECS[i].el);
      if (VECS[i].ckr) chk(string'(VECS[i].tag), r_rd, VECS[i].er);
      chk(string'(VECS[i].tag), {15'd0, l_int_n}, {15'd0, VECS[i].eli});
      chk(string'(VECS[i].tag), {15'd0, r_int_n}, {15'd0, VECS[i].eri});
    end

    // R8: busy of the setting port blocks the set
    idle(); l_busy_n = 0; l_op(1, 10'd1023, 16'hDEAD); tick();
    chk("R8", {15'd0, r_int_n}, 16'd1);
    l_busy_n = 1; l_op(1, 10'd1023, 16'hDEAD); tick();
    chk("R5", {15'd0, r_int_n}, 16'd0);
    // R8: busy of the clearing port blocks the clear, data still read
    idle(); r_busy_n = 0; r_op(0, 10'd1023, 16'h0); tick();
    chk("R8", r_rd, 16'hDEAD);
    chk("R8", {15'd0, r_int_n}, 16'd0);
    r_busy_n = 1; r_op(0, 10'd1023, 16'h0); tick();
    chk("R6", {15'd0, r_int_n}, 16'd1);

    // R11: access without output enable is not a read
    idle(); r_op(1, 10'd1022, 16'h0BAD); tick();
    chk("R7", {15'd0, l_int_n}, 16'd0);
    idle(); l_ce = 1; l_we = 0; l_oe = 0; l_addr = 10'd1022; tick();
    chk("R11", {15'd0, l_int_n}, 16'd0);
    chk("R11", l_rd, 16'h0002);
    idle(); l_op(0, 10'd1022, 16'h0); tick();
    chk("R7", l_rd, 16'h0BAD);
    chk("R7", {15'd0, l_int_n}, 16'd1);

    // R1: reset during operation
    idle(); l_op(1, 10'd1023, 16'h7777); r_op(1, 10'd1022, 16'h8888); tick();
    chk("R5", {15'd0, r_int_n}, 16'd0);
    idle(); rst_ni = 1'b0; #1;
    chk("R1", {15'd0, l_int_n}, 16'd1);
    chk("R1", {15'd0, r_int_n}, 16'd1);
    chk("R1", l_rd, 16'h0);
    chk("R1", r_rd, 16'h0);
    @(negedge clk); rst_ni = 1'b1; tick();
    summary();
  end
endmodule